// File: doc/BRIEF.md
# Flag-Coupled Pin Operation Unit

This unit carries out the single-cycle pin instructions of a small processor core on a port of up to 64 pins. An instruction names a pin with a 6-bit field. It can release the pin to input, drive it low or high, or invert it. It can also drive the pin from the carry flag, the zero flag, or the inverse of either. Two read instructions copy the synchronised pin level into the carry and zero flags, in opposite senses. The unit holds the two flags. The core's ALU writes them through a pair of explicit write strobes.

A mapping instruction couples each flag to a pin of its own choice, and each coupling has its own enable. While a coupled pin is an output, the pin shows the current flag level in every cycle. While it is an input, the flag copies the synchronised pin level on every clock. This lets a rotate-through-carry loop shift one bit per instruction out of or into a pin. With both flags coupled to input pins, the core can branch on two external events without polling them. Every pad input passes through a two-flop synchroniser before any flag sees it.

Top module: `flagPinUnit`

## Requirements
- R1: After reset every pin is an input (padOe all 0) with output latch 0. Both flags are 0 and both couplings are disabled, with the coupled pin numbers set to 0.
- R2: opCode 1 (release) clears padOe of the addressed pin at the next clock and leaves its output latch unchanged.
- R3: opCode 2 drives the addressed pin low, opCode 3 drives it high and opCode 4 inverts its output latch. Each of them sets padOe of that pin. The effect is visible after the next clock.
- R4: opCodes 5, 6, 7 and 8 set padOe of the pin and load its latch with carry, inverted carry, zero and inverted zero. The flag used is the value held in the cycle the instruction is issued.
- R5: opCode 9 loads carry with the synchronised pin level and zero with its inverse. opCode 10 loads carry with the inverse and zero with the level. A level held on padIn before clock edge k is seen by a read issued after edge k+1.
- R6: opCode 11 couples carry to pin opPin with enable opEnC, and zero to pin opPinB with enable opEnZ. The coupling is in force from the next cycle.
- R7: While a coupled pin has padOe set, padOut of that pin equals the coupled flag in every cycle. If both flags are coupled to the same pin, carry is shown.
- R8: While a coupled pin has padOe clear, its flag takes the synchronised pin level at every clock. Both flags can follow two input pins at once.
- R9: Per flag, the order of priority is: the core write strobe first, then a read instruction, then the coupled-pin sample.
- R10: A pin number of NUM_PINS or more changes nothing. For opCode 11, an out-of-range field leaves only its own coupling unchanged.
- R11: opCodes 0 and 12 to 15, and any cycle with opValid low, change no pin, flag or coupling. Core flag writes still take effect in such cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Pin instruction present this cycle |
| opCode | input | 4 | Pin instruction code |
| opPin | input | 6 | Target pin, or carry pin for coupling |
| opPinB | input | 6 | Zero pin for coupling |
| opEnC | input | 1 | Carry coupling enable for opCode 11 |
| opEnZ | input | 1 | Zero coupling enable for opCode 11 |
| coreWrC | input | 1 | ALU writes carry this cycle |
| coreC | input | 1 | Carry value from ALU |
| coreWrZ | input | 1 | ALU writes zero this cycle |
| coreZ | input | 1 | Zero value from ALU |
| padIn | input | NUM_PINS | Pad input levels |
| padOut | output | NUM_PINS | Pad output levels |
| padOe | output | NUM_PINS | Pad output enables |
| flagC | output | 1 | Carry flag |
| flagZ | output | 1 | Zero flag |

## Verification
The hardest situation to reach is a single cycle in which a coupled input sample, a read instruction and an ALU flag write all aim at the same flag. The input level must have entered the synchroniser two edges earlier for the sample to differ from the flag's current value. The bench works on an 8-pin instance. It tracks a level-accurate model of the synchroniser pipeline, so every stimulus cycle has a known synchronised value. It sweeps each opcode across all 64 pin numbers, with random pad levels, random ALU writes and random coupling fields. Directed sequences then stack the three flag sources in the same cycle and couple both flags to one output pin.

// File: rtl/flagPinPkg.sv
package flagPinPkg;
  localparam int PIN_W = 6;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_REL   = 4'd1,
    OP_LOW   = 4'd2,
    OP_HIGH  = 4'd3,
    OP_FLIP  = 4'd4,
    OP_DRVC  = 4'd5,
    OP_DRVNC = 4'd6,
    OP_DRVZ  = 4'd7,
    OP_DRVNZ = 4'd8,
    OP_RD    = 4'd9,
    OP_RDN   = 4'd10,
    OP_MAP   = 4'd11
  } pinOp_e;

  // strobes from control to datapath for one pin write
  typedef struct packed {
    logic             wrEn;
    logic [PIN_W-1:0] pin;
    logic             oeVal;
    logic             setOut;
    logic             outVal;
    logic             flipOut;
  } pinCmd_t;

  typedef struct packed {
    logic             enC;
    logic [PIN_W-1:0] pinC;
    logic             enZ;
    logic [PIN_W-1:0] pinZ;
  } flagMap_t;
endpackage

// File: rtl/flagPinCtrl.sv
module flagPinCtrl
  import flagPinPkg::*;
#(
  parameter int NUM_PINS = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                opValid,
  input  logic [3:0]          opCode,
  input  logic [PIN_W-1:0]    opPin,
  input  logic [PIN_W-1:0]    opPinB,
  input  logic                opEnC,
  input  logic                opEnZ,
  input  logic                coreWrC,
  input  logic                coreC,
  input  logic                coreWrZ,
  input  logic                coreZ,
  input  logic [NUM_PINS-1:0] syncVec,
  input  logic [NUM_PINS-1:0] oeVec,
  output pinCmd_t             cmd,
  output flagMap_t            mapCfg,
  output logic                flagC,
  output logic                flagZ
);
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic             opInRange;
  logic             bInRange;
  logic [IDX_W-1:0] opIdx;
  logic [IDX_W-1:0] mapIdxC;
  logic [IDX_W-1:0] mapIdxZ;
  logic             rdHit;
  logic             rdInv;
  logic             rdBit;
  logic             nextC;
  logic             nextZ;
  flagMap_t         nextMap;

  assign opInRange = 32'(opPin) < 32'(NUM_PINS);
  assign bInRange  = 32'(opPinB) < 32'(NUM_PINS);
  assign opIdx     = opPin[IDX_W-1:0];
  assign mapIdxC   = mapCfg.pinC[IDX_W-1:0];
  assign mapIdxZ   = mapCfg.pinZ[IDX_W-1:0];

  // decode pin-writing instructions into datapath strobes
  always_comb begin
    cmd     = '0;
    cmd.pin = opPin;
    if (opValid && opInRange) begin
      case (opCode)
        OP_REL:   begin cmd.wrEn = 1'b1; cmd.oeVal = 1'b0; end
        OP_LOW:   begin cmd.wrEn = 1'b1; cmd.oeVal = 1'b1; cmd.setOut = 1'b1; cmd.outVal = 1'b0; end
        OP_HIGH:  begin cmd.wrEn = 1'b1; cmd.oeVal = 1'b1; cmd.setOut = 1'b1; cmd.outVal = 1'b1; end
        OP_FLIP:  begin cmd.wrEn = 1'b1; cmd.oeVal = 1'b1; cmd.flipOut = 1'b1; end
        OP_DRVC:  begin cmd.wrEn = 1'b1; cmd.oeVal = 1'b1; cmd.setOut = 1'b1; cmd.outVal = flagC; end
        OP_DRVNC: begin cmd.wrEn = 1'b1; cmd.oeVal = 1'b1; cmd.setOut = 1'b1; cmd.outVal = ~flagC; end
        OP_DRVZ:  begin cmd.wrEn = 1'b1; cmd.oeVal = 1'b1; cmd.setOut = 1'b1; cmd.outVal = flagZ; end
        OP_DRVNZ: begin cmd.wrEn = 1'b1; cmd.oeVal = 1'b1; cmd.setOut = 1'b1; cmd.outVal = ~flagZ; end
        default:  ;
      endcase
    end
  end

  assign rdHit = opValid && opInRange && ((opCode == OP_RD) || (opCode == OP_RDN));
  assign rdInv = (opCode == OP_RDN);
  assign rdBit = syncVec[opIdx];

  // flag sources, lowest priority first
  always_comb begin
    nextC = flagC;
    nextZ = flagZ;
    if (mapCfg.enC && !oeVec[mapIdxC]) nextC = syncVec[mapIdxC];
    if (mapCfg.enZ && !oeVec[mapIdxZ]) nextZ = syncVec[mapIdxZ];
    if (rdHit) begin
      nextC = rdBit ^ rdInv;
      nextZ = ~rdBit ^ rdInv;
    end
    if (coreWrC) nextC = coreC;
    if (coreWrZ) nextZ = coreZ;
  end

  always_comb begin
    nextMap = mapCfg;
    if (opValid && (opCode == OP_MAP)) begin
      if (opInRange) begin
        nextMap.enC  = opEnC;
        nextMap.pinC = opPin;
      end
      if (bInRange) begin
        nextMap.enZ  = opEnZ;
        nextMap.pinZ = opPinB;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagC  <= 1'b0;
      flagZ  <= 1'b0;
      mapCfg <= '0;
    end else begin
      flagC  <= nextC;
      flagZ  <= nextZ;
      mapCfg <= nextMap;
    end
  end

  // R9
  core_c_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    coreWrC |=> flagC == $past(coreC));

  // R9
  core_z_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    coreWrZ |=> flagZ == $past(coreZ));

  // R5
  read_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdHit && !coreWrC && !coreWrZ) |=>
      (flagC == ($past(rdBit) ^ $past(rdInv))) && (flagZ == (~$past(rdBit) ^ $past(rdInv))));

  // R8
  map_follow_c_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mapCfg.enC && !oeVec[mapIdxC] && !rdHit && !coreWrC) |=> flagC == $past(syncVec[mapIdxC]));

  // R8
  map_follow_z_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mapCfg.enZ && !oeVec[mapIdxZ] && !rdHit && !coreWrZ) |=> flagZ == $past(syncVec[mapIdxZ]));

  // R10
  map_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode == OP_MAP) && !opInRange) |=> $stable(mapCfg.pinC) && $stable(mapCfg.enC));
endmodule

// File: rtl/flagPinData.sv
module flagPinData
  import flagPinPkg::*;
#(
  parameter int NUM_PINS = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  pinCmd_t             cmd,
  input  flagMap_t            mapCfg,
  input  logic                flagC,
  input  logic                flagZ,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] syncVec,
  output logic [NUM_PINS-1:0] oeVec
);
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic [NUM_PINS-1:0] outReg;
  logic [NUM_PINS-1:0] oeReg;
  logic [NUM_PINS-1:0] syncA;
  logic [NUM_PINS-1:0] syncB;
  logic [IDX_W-1:0]    cmdIdx;
  logic [1:0]          warmCnt;

  assign cmdIdx = cmd.pin[IDX_W-1:0];

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      logic hitC;
      logic hitZ;
      logic sel;

      assign sel  = cmd.wrEn && (cmd.pin == PIN_W'(i));
      assign hitC = mapCfg.enC && (mapCfg.pinC == PIN_W'(i));
      assign hitZ = mapCfg.enZ && (mapCfg.pinZ == PIN_W'(i));

      always_ff @(posedge clk) begin
        if (!rstN) begin
          outReg[i] <= 1'b0;
          oeReg[i]  <= 1'b0;
        end else if (sel) begin
          oeReg[i] <= cmd.oeVal;
          if (cmd.setOut)       outReg[i] <= cmd.outVal;
          else if (cmd.flipOut) outReg[i] <= ~outReg[i];
        end
      end

      // carry coupling outranks zero coupling on a shared pin
      assign padOut[i] = hitC ? flagC : (hitZ ? flagZ : outReg[i]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA   <= '0;
      syncB   <= '0;
      warmCnt <= 2'd0;
    end else begin
      syncA   <= padIn;
      syncB   <= syncA;
      if (warmCnt != 2'd2) warmCnt <= warmCnt + 2'd1;
    end
  end

  assign padOe   = oeReg;
  assign oeVec   = oeReg;
  assign syncVec = syncB;

  // R2
  release_keeps_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.wrEn && !cmd.oeVal) |=> !oeReg[$past(cmdIdx)] && $stable(outReg));

  // R3
  flip_inverts_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.wrEn && cmd.flipOut) |=> outReg[$past(cmdIdx)] == !$past(outReg[cmdIdx]));

  // R5
  sync_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt == 2'd2) |-> syncB == $past(padIn, 2));

  // R11
  idle_holds_pins_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.wrEn |=> $stable(oeReg) && $stable(outReg));
endmodule

// File: rtl/flagPinUnit.sv
module flagPinUnit
  import flagPinPkg::*;
#(
  parameter int NUM_PINS = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                opValid,
  input  logic [3:0]          opCode,
  input  logic [5:0]          opPin,
  input  logic [5:0]          opPinB,
  input  logic                opEnC,
  input  logic                opEnZ,
  input  logic                coreWrC,
  input  logic                coreC,
  input  logic                coreWrZ,
  input  logic                coreZ,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic                flagC,
  output logic                flagZ
);
  pinCmd_t             cmd;
  flagMap_t            mapCfg;
  logic [NUM_PINS-1:0] syncVec;
  logic [NUM_PINS-1:0] oeVec;

  flagPinCtrl #(.NUM_PINS(NUM_PINS)) u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .opPin(opPin), .opPinB(opPinB), .opEnC(opEnC), .opEnZ(opEnZ),
    .coreWrC(coreWrC), .coreC(coreC), .coreWrZ(coreWrZ), .coreZ(coreZ),
    .syncVec(syncVec), .oeVec(oeVec), .cmd(cmd), .mapCfg(mapCfg),
    .flagC(flagC), .flagZ(flagZ)
  );

  flagPinData #(.NUM_PINS(NUM_PINS)) u_data (
    .clk(clk), .rstN(rstN), .cmd(cmd), .mapCfg(mapCfg),
    .flagC(flagC), .flagZ(flagZ), .padIn(padIn), .padOut(padOut),
    .padOe(padOe), .syncVec(syncVec), .oeVec(oeVec)
  );
endmodule

// File: tb/flagPinUnit_test.sv
module flagPinUnit_test;
  localparam int CLK_NS = 10;
  localparam int NP     = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          opValid = 1'b0;
  logic [3:0]    opCode = '0;
  logic [5:0]    opPin = '0;
  logic [5:0]    opPinB = '0;
  logic          opEnC = 1'b0, opEnZ = 1'b0;
  logic          coreWrC = 1'b0, coreC = 1'b0, coreWrZ = 1'b0, coreZ = 1'b0;
  logic [NP-1:0] padIn = '0;
  logic [NP-1:0] padOut, padOe;
  logic          flagC, flagZ;

  int vectors = 0;
  int misses  = 0;

  // bench-side expected state
  logic [NP-1:0] eOut = '0, eOe = '0, s1 = '0, s2 = '0;
  logic          eC = 1'b0, eZ = 1'b0, mC = 1'b0, mZ = 1'b0;
  logic [5:0]    pC = '0, pZ = '0;
  logic [31:0]   rnd = 32'h1234_5678;

  flagPinUnit #(.NUM_PINS(NP)) uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .opPin(opPin), .opPinB(opPinB), .opEnC(opEnC), .opEnZ(opEnZ),
    .coreWrC(coreWrC), .coreC(coreC), .coreWrZ(coreWrZ), .coreZ(coreZ),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .flagC(flagC), .flagZ(flagZ)
  );

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [31:0] nextRnd(logic [31:0] x);
    logic [31:0] y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  function automatic logic [NP-1:0] expPadOut();
    logic [NP-1:0] v = eOut;
    for (int i = 0; i < NP; i++) begin
      if (mC && pC == 6'(i))      v[i] = eC;
      else if (mZ && pZ == 6'(i)) v[i] = eZ;
    end
    return v;
  endfunction

  task automatic compare(string tag);
    logic [NP-1:0] xo = expPadOut();
    vectors++;
    if (padOut !== xo || padOe !== eOe || flagC !== eC || flagZ !== eZ) begin
      misses++;
      $display("FAIL %s: out=%b oe=%b c=%b z=%b expected out=%b oe=%b c=%b z=%b",
               tag, padOut, padOe, flagC, flagZ, xo, eOe, eC, eZ);
    end
  endtask

  // one clock: compute expected next state from current inputs, then compare
  task automatic tick(string tag);
    logic [NP-1:0] nOut = eOut, nOe = eOe;
    logic nC = eC, nZ = eZ, nmC = mC, nmZ = mZ;
    logic [5:0] npC = pC, npZ = pZ;
    logic inR = opPin < 6'(NP);
    logic [2:0] i = opPin[2:0];
    if (mC && !eOe[pC[2:0]]) nC = s2[pC[2:0]];
    if (mZ && !eOe[pZ[2:0]]) nZ = s2[pZ[2:0]];
    if (opValid && inR) begin
      case (opCode)
        4'd1:  nOe[i] = 1'b0;
        4'd2:  begin nOe[i] = 1'b1; nOut[i] = 1'b0; end
        4'd3:  begin nOe[i] = 1'b1; nOut[i] = 1'b1; end
        4'd4:  begin nOe[i] = 1'b1; nOut[i] = ~eOut[i]; end
        4'd5:  begin nOe[i] = 1'b1; nOut[i] = eC; end
        4'd6:  begin nOe[i] = 1'b1; nOut[i] = ~eC; end
        4'd7:  begin nOe[i] = 1'b1; nOut[i] = eZ; end
        4'd8:  begin nOe[i] = 1'b1; nOut[i] = ~eZ; end
        4'd9:  begin nC = s2[i]; nZ = ~s2[i]; end
        4'd10: begin nC = ~s2[i]; nZ = s2[i]; end
        default: ;
      endcase
    end
    if (opValid && opCode == 4'd11) begin
      if (inR)            begin nmC = opEnC; npC = opPin; end
      if (opPinB < 6'(NP)) begin nmZ = opEnZ; npZ = opPinB; end
    end
    if (coreWrC) nC = coreC;
    if (coreWrZ) nZ = coreZ;
    @(posedge clk);
    eOut = nOut; eOe = nOe; eC = nC; eZ = nZ;
    mC = nmC; mZ = nmZ; pC = npC; pZ = npZ;
    s2 = s1; s1 = padIn;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle();
    opValid = 1'b0; opCode = '0; coreWrC = 1'b0; coreWrZ = 1'b0;
  endtask

  task automatic doOp(logic [3:0] c, logic [5:0] p, string tag);
    opValid = 1'b1; opCode = c; opPin = p;
    tick(tag);
    idle();
  endtask

  task automatic doMap(logic [5:0] pc, logic ec, logic [5:0] pz, logic ez, string tag);
    opValid = 1'b1; opCode = 4'd11; opPin = pc; opPinB = pz; opEnC = ec; opEnZ = ez;
    tick(tag);
    idle();
  endtask

  function automatic string sweepTag(int op, int pin);
    if (op == 0 || op >= 12) return "R11";
    if (op == 11) return (pin >= NP) ? "R10" : "R6";
    if (pin >= NP) return "R10";
    if (op == 1) return "R2";
    if (op <= 4) return "R3";
    if (op <= 8) return "R4";
    return "R5";
  endfunction

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 200000);
    misses++;
    $display("FAIL watchdog: run did not end, expected completion");
    finishRun();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    compare("R1");

    // sweep every opcode over every 6-bit pin number with random side inputs
    for (int op = 0; op < 16; op++) begin
      for (int pin = 0; pin < 64; pin++) begin
        rnd = nextRnd(rnd);
        opValid = 1'b1; opCode = 4'(op); opPin = 6'(pin);
        opPinB  = rnd[5:0]; opEnC = rnd[6]; opEnZ = rnd[7];
        padIn   = rnd[15:8];
        coreWrC = (rnd[19:16] == 4'd0); coreC = rnd[20];
        coreWrZ = (rnd[24:21] == 4'd0); coreZ = rnd[25];
        tick(sweepTag(op, pin));
      end
    end

    // R11: instructions presented with opValid low
    for (int k = 0; k < 64; k++) begin
      rnd = nextRnd(rnd);
      opValid = 1'b0; opCode = rnd[3:0]; opPin = rnd[9:4]; opPinB = rnd[15:10];
      opEnC = rnd[16]; opEnZ = rnd[17]; padIn = rnd[25:18];
      coreWrC = 1'b0; coreWrZ = 1'b0;
      tick("R11");
    end
    idle();

    // R7: flags shown on output pins, carry wins on a shared pin
    doMap(6'd0, 1'b0, 6'd0, 1'b0, "R6");
    doOp(4'd3, 6'd2, "R3");
    doOp(4'd2, 6'd3, "R3");
    doMap(6'd2, 1'b1, 6'd3, 1'b1, "R7");
    for (int k = 0; k < 8; k++) begin
      coreWrC = 1'b1; coreC = k[0]; coreWrZ = 1'b1; coreZ = k[1];
      tick("R7");
    end
    idle();
    doOp(4'd3, 6'd4, "R3");
    doMap(6'd4, 1'b1, 6'd4, 1'b1, "R7");
    for (int k = 0; k < 4; k++) begin
      coreWrC = 1'b1; coreC = k[0]; coreWrZ = 1'b1; coreZ = ~k[0];
      tick("R7");
    end
    idle();

    // R8: both flags follow two input pins through the synchroniser
    doOp(4'd1, 6'd5, "R2");
    doOp(4'd1, 6'd6, "R2");
    doMap(6'd5, 1'b1, 6'd6, 1'b1, "R8");
    for (int k = 0; k < 16; k++) begin
      padIn = NP'(k * 37);
      tick("R8");
    end

    // R9: coupled sample, read instruction and core write in the same cycle
    for (int k = 0; k < 16; k++) begin
      padIn = NP'(~(k * 13));
      opValid = 1'b1; opCode = k[0] ? 4'd9 : 4'd10; opPin = 6'(k % NP);
      coreWrC = k[1]; coreC = k[2]; coreWrZ = k[2]; coreZ = k[3];
      tick("R9");
    end
    idle();

    // R5: a single level step observed through a read two edges later
    doMap(6'd0, 1'b0, 6'd0, 1'b0, "R6");
    doOp(4'd1, 6'd1, "R2");
    padIn = '0;
    repeat (3) tick("R5");
    padIn = 8'h02;
    opValid = 1'b1; opCode = 4'd9; opPin = 6'd1;
    repeat (4) tick("R5");
    idle();

    finishRun();
  end
endmodule